// File: doc/BRIEF.md
# Two-Line Serial Register Access Master

The block reads and writes 32-bit registers in up to eight slave devices. The slaves sit on two independent half-duplex serial lines, with four slaves on each line. The host raises one request at a time with a device number, a register index, write data and a direction flag. The block answers in the same cycle with accept or refuse. An accepted request is framed as a byte sequence and handed, byte by byte, to a byte-level transmitter on the selected line over a valid/ready pair.

After a read frame has gone out, the line collects eight reply bytes from its receiver and presents them as one word together with a completion pulse. The host clocks the block and also supplies a millisecond tick. The tick bounds both the sending phase and the reply wait. A read that times out while waiting for its reply marks that device in a sticky not-found mask. The mask is kept until reset or until the host clears it. Each line has its own sequencer, timer and reply buffer, so the two lines can be busy at the same time.

Top module: `uart_reg_master`

## Requirements
- R1: The device number picks the line from its bit 2 (devices 0..3 on line 0, 4..7 on line 1), and its bits 1:0 give the slave address placed in frame byte 1 (upper six bits zero).
- R2: Frame byte 0 is 0xA0 and frame byte 2 is the register index (7 bits) shifted left by one, with bit 0 set to 1 for a write and 0 for a read.
- R3: A write frame has 8 bytes: bytes 3..6 hold the write data most-significant byte first, and byte 7 is a check byte. A read frame has 4 bytes, and byte 3 is the check byte. The check byte is a CRC-8 with polynomial 0x07 and initial value 0. It runs over all earlier bytes of the frame, feeding each byte least-significant bit first.
- R4: A request is refused, with req_nak_o high in the same cycle and no byte sent, when the device number is 8 or more, when bit 7 of the register index is set, or when the selected line is busy.
- R5: A request for an idle line is accepted (req_ack_o in the same cycle) while the other line is busy. Both lines then run independently.
- R6: A write raises wr_done_o on its line for one cycle right after the last frame byte is taken, and the line is idle in the following cycle.
- R7: A read waits for exactly 8 reply bytes, then raises rd_done_o for one cycle. At that point the line's reply_o field holds the first received byte in bits 7:0 and the k-th byte in bits 8k+7:8k. The line is idle in the following cycle.
- R8: Each line's timer restarts when a request is accepted and again when a read frame has been sent. If the timer counts TIMEOUT_MS+1 ticks (21 by default) before the phase ends, the line pulses timeout_o for one cycle and is idle.
- R9: A timeout in the reply wait sets bit (line*4 + address) of notfound_o one cycle after the timeout pulse. A timeout while sending leaves the mask unchanged.
- R10: notfound_o is zero after reset, bits are only ever set, and a cycle with clear_nf_i high zeroes the mask from the next cycle.
- R11: Bytes arriving on a line's receiver while that line is not waiting for a reply are dropped and never appear in reply_o.
- R12: req_ack_o and req_nak_o are never high together, and one of them is high in every cycle in which req_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| req_valid_i | input | 1 | Host request present |
| req_dev_i | input | 4 | Device number |
| req_reg_i | input | 8 | Register index (bit 7 must be zero) |
| req_wdata_i | input | 32 | Write data |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ack_o | output | 1 | Request accepted this cycle |
| req_nak_o | output | 1 | Request refused this cycle |
| tx_valid_o | output | 2 | Per line: byte offered to the transmitter |
| tx_data_o | output | 16 | Per line: byte offered, line l at bits 8l+7:8l |
| tx_ready_i | input | 2 | Per line: transmitter takes the byte |
| rx_valid_i | input | 2 | Per line: received byte present |
| rx_data_i | input | 16 | Per line: received byte, line l at bits 8l+7:8l |
| busy_o | output | 2 | Per line: transaction in progress |
| wr_done_o | output | 2 | Per line: write finished pulse |
| rd_done_o | output | 2 | Per line: reply captured pulse |
| timeout_o | output | 2 | Per line: timeout pulse |
| reply_o | output | 128 | Per line: 8 reply bytes, line l at bits 64l+63:64l |
| clear_nf_i | input | 1 | Clear the not-found mask |
| notfound_o | output | 8 | Sticky not-found mask, bit = line*4 + address |

## Verification
A write on line 0 and a read on line 1 run against a transmitter that accepts every cycle and one that accepts every other cycle. This separates correct byte order and check-byte generation from errors that appear only under backpressure. While line 1 is busy, a second request for line 1 must be refused and a request for line 0 must still be accepted, so per-line busy is checked independently of global busy. A silent slave and a transmitter that never accepts both drive a line into timeout. The bench counts the ticks from the phase start to the timeout pulse, and the two cases tell apart the reply-wait timeout, which marks the mask, from the send timeout, which does not. Stray receiver bytes sent before a read must not shift the captured reply.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  typedef enum logic [2:0] {
    LN_IDLE, LN_TX, LN_TX_DONE, LN_RX, LN_RX_DONE
  } line_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hA0;
  localparam logic [7:0] CRC_POLY  = 8'h07;
endpackage

// File: rtl/crc8_step.sv
module crc8_step
  import uart_reg_pkg::*;
(
  input  logic [7:0] crc_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  always_comb begin
    logic [7:0] c;
    logic [7:0] d;
    c = crc_i;
    d = data_i;
    for (int j = 0; j < 8; j++) begin
      if (c[7] ^ d[0]) c = {c[6:0], 1'b0} ^ CRC_POLY;
      else             c = {c[6:0], 1'b0};
      d = {1'b0, d[7:1]};
    end
    crc_o = c;
  end
endmodule

// File: rtl/uart_reg_line.sv
module uart_reg_line
  import uart_reg_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int TIMEOUT_MS  = 20,
  parameter int REPLY_BYTES = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_ms_i,
  input  logic                     start_i,
  input  logic                     write_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [6:0]               reg_i,
  input  logic [31:0]              wdata_i,
  output logic                     busy_o,
  output logic                     tx_valid_o,
  output logic [7:0]               tx_data_o,
  input  logic                     tx_ready_i,
  input  logic                     rx_valid_i,
  input  logic [7:0]               rx_data_i,
  output logic                     wr_done_o,
  output logic                     rd_done_o,
  output logic                     timeout_o,
  output logic                     nf_set_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [REPLY_BYTES*8-1:0] reply_o
);
  localparam int TCNT_W = $clog2(TIMEOUT_MS + 2);
  localparam int RIDX_W = (REPLY_BYTES > 1) ? $clog2(REPLY_BYTES) : 1;

  line_state_e              state_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [6:0]               reg_q;
  logic [31:0]              wdata_q;
  logic                     write_q;
  logic [2:0]               idx_q;
  logic [7:0]               crc_q, crc_nx;
  logic [TCNT_W-1:0]        tcnt_q;
  logic [RIDX_W-1:0]        ridx_q;
  logic [REPLY_BYTES*8-1:0] reply_q;
  logic                     to_q, nf_q;
  logic [7:0]               frame_b;
  logic [2:0]               last_idx;
  logic                     expire;

  assign last_idx = write_q ? 3'd7 : 3'd3;
  assign expire   = tick_ms_i && (tcnt_q >= TCNT_W'(TIMEOUT_MS));

  always_comb begin
    case (idx_q)
      3'd0:    frame_b = SYNC_BYTE;
      3'd1:    frame_b = 8'(addr_q);
      3'd2:    frame_b = {reg_q, write_q};
      3'd3:    frame_b = wdata_q[31:24];
      3'd4:    frame_b = wdata_q[23:16];
      3'd5:    frame_b = wdata_q[15:8];
      default: frame_b = wdata_q[7:0];
    endcase
  end

  assign tx_data_o = (idx_q == last_idx) ? crc_q : frame_b;

  crc8_step u_crc (.crc_i(crc_q), .data_i(tx_data_o), .crc_o(crc_nx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LN_IDLE;
      addr_q  <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      idx_q   <= '0;
      crc_q   <= '0;
      tcnt_q  <= '0;
      ridx_q  <= '0;
      reply_q <= '0;
      to_q    <= 1'b0;
      nf_q    <= 1'b0;
    end else begin
      to_q <= 1'b0;
      nf_q <= 1'b0;
      case (state_q)
        LN_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          reg_q   <= reg_i;
          wdata_q <= wdata_i;
          write_q <= write_i;
          idx_q   <= '0;
          crc_q   <= '0;
          tcnt_q  <= '0;
          state_q <= LN_TX;
        end
        LN_TX: begin
          if (tick_ms_i) tcnt_q <= tcnt_q + 1'b1;
          if (tx_ready_i) begin
            crc_q <= crc_nx;
            idx_q <= idx_q + 1'b1;
            if (idx_q == last_idx) begin
              if (write_q) state_q <= LN_TX_DONE;
              else begin
                state_q <= LN_RX;
                tcnt_q  <= '0;
                ridx_q  <= '0;
              end
            end
          end else if (expire) begin
            state_q <= LN_IDLE;
            to_q    <= 1'b1;
          end
        end
        LN_RX: begin
          if (tick_ms_i) tcnt_q <= tcnt_q + 1'b1;
          if (rx_valid_i) begin
            reply_q[ridx_q*8 +: 8] <= rx_data_i;
            ridx_q <= ridx_q + 1'b1;
            if (ridx_q == RIDX_W'(REPLY_BYTES - 1)) state_q <= LN_RX_DONE;
          end else if (expire) begin
            state_q <= LN_IDLE;
            to_q    <= 1'b1;
            nf_q    <= 1'b1;
          end
        end
        default: state_q <= LN_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != LN_IDLE);
  assign tx_valid_o = (state_q == LN_TX);
  assign wr_done_o  = (state_q == LN_TX_DONE);
  assign rd_done_o  = (state_q == LN_RX_DONE);
  assign timeout_o  = to_q;
  assign nf_set_o   = nf_q;
  assign addr_o     = addr_q;
  assign reply_o    = reply_q;
endmodule

// File: rtl/uart_reg_master.sv
module uart_reg_master
  import uart_reg_pkg::*;
#(
  parameter int N_LINES         = 2,
  parameter int SLAVES_PER_LINE = 4,
  parameter int TIMEOUT_MS      = 20,
  parameter int REPLY_BYTES     = 8,
  localparam int ADDR_W = $clog2(SLAVES_PER_LINE),
  localparam int N_DEV  = N_LINES * SLAVES_PER_LINE,
  localparam int DEV_W  = $clog2(N_DEV) + 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tick_ms_i,
  input  logic                             req_valid_i,
  input  logic [DEV_W-1:0]                 req_dev_i,
  input  logic [7:0]                       req_reg_i,
  input  logic [31:0]                      req_wdata_i,
  input  logic                             req_write_i,
  output logic                             req_ack_o,
  output logic                             req_nak_o,
  output logic [N_LINES-1:0]               tx_valid_o,
  output logic [N_LINES*8-1:0]             tx_data_o,
  input  logic [N_LINES-1:0]               tx_ready_i,
  input  logic [N_LINES-1:0]               rx_valid_i,
  input  logic [N_LINES*8-1:0]             rx_data_i,
  output logic [N_LINES-1:0]               busy_o,
  output logic [N_LINES-1:0]               wr_done_o,
  output logic [N_LINES-1:0]               rd_done_o,
  output logic [N_LINES-1:0]               timeout_o,
  output logic [N_LINES*REPLY_BYTES*8-1:0] reply_o,
  input  logic                             clear_nf_i,
  output logic [N_DEV-1:0]                 notfound_o
);
  localparam int LINE_W = DEV_W - ADDR_W;

  logic [LINE_W-1:0] dev_line;
  logic              dev_ok, accept;
  logic [N_LINES-1:0] nf_set;
  logic [ADDR_W-1:0]  line_addr [N_LINES];
  logic [N_DEV-1:0]   nf_q, nf_hit;

  assign dev_line  = req_dev_i[ADDR_W +: LINE_W];
  assign dev_ok    = (req_dev_i < DEV_W'(N_DEV));
  assign accept    = req_valid_i && dev_ok && !req_reg_i[7] && !busy_o[dev_line];
  assign req_ack_o = accept;
  assign req_nak_o = req_valid_i && !accept;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    uart_reg_line #(
      .ADDR_W(ADDR_W), .TIMEOUT_MS(TIMEOUT_MS), .REPLY_BYTES(REPLY_BYTES)
    ) u_line (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_ms_i  (tick_ms_i),
      .start_i    (accept && (dev_line == LINE_W'(l))),
      .write_i    (req_write_i),
      .addr_i     (req_dev_i[ADDR_W-1:0]),
      .reg_i      (req_reg_i[6:0]),
      .wdata_i    (req_wdata_i),
      .busy_o     (busy_o[l]),
      .tx_valid_o (tx_valid_o[l]),
      .tx_data_o  (tx_data_o[l*8 +: 8]),
      .tx_ready_i (tx_ready_i[l]),
      .rx_valid_i (rx_valid_i[l]),
      .rx_data_i  (rx_data_i[l*8 +: 8]),
      .wr_done_o  (wr_done_o[l]),
      .rd_done_o  (rd_done_o[l]),
      .timeout_o  (timeout_o[l]),
      .nf_set_o   (nf_set[l]),
      .addr_o     (line_addr[l]),
      .reply_o    (reply_o[l*REPLY_BYTES*8 +: REPLY_BYTES*8])
    );
  end

  always_comb begin
    nf_hit = '0;
    for (int l = 0; l < N_LINES; l++)
      if (nf_set[l]) nf_hit[l*SLAVES_PER_LINE + int'(line_addr[l])] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nf_q <= '0;
    else         nf_q <= (clear_nf_i ? '0 : nf_q) | nf_hit;
  end

  assign notfound_o = nf_q;
endmodule

// File: rtl/uart_reg_master_chk.sv
module uart_reg_master_chk #(
  parameter int N_LINES         = 2,
  parameter int SLAVES_PER_LINE = 4,
  parameter int ADDR_W          = 2,
  parameter int N_DEV           = 8,
  parameter int DEV_W           = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [DEV_W-1:0]     req_dev_i,
  input logic [7:0]           req_reg_i,
  input logic                 req_ack_o,
  input logic                 req_nak_o,
  input logic [N_LINES-1:0]   tx_valid_o,
  input logic [N_LINES*8-1:0] tx_data_o,
  input logic [N_LINES-1:0]   busy_o,
  input logic [N_LINES-1:0]   wr_done_o,
  input logic [N_LINES-1:0]   rd_done_o,
  input logic [N_LINES-1:0]   timeout_o,
  input logic                 clear_nf_i,
  input logic [N_DEV-1:0]     notfound_o
);
  localparam int LINE_W = DEV_W - ADDR_W;

  AST_ACK_NAK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ack_o && req_nak_o)); // R12
  AST_VALID_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (req_ack_o || req_nak_o)); // R12
  AST_BAD_DEV_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_dev_i >= DEV_W'(N_DEV)) |-> req_nak_o); // R4
  AST_BAD_REG_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_reg_i[7]) |-> req_nak_o); // R4
  AST_NF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_nf_i |=> ((notfound_o & $past(notfound_o)) == $past(notfound_o))); // R10

  for (genvar l = 0; l < N_LINES; l++) begin : g_chk
    AST_SYNC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_ack_o && req_dev_i[ADDR_W +: LINE_W] == LINE_W'(l))
      |=> (tx_valid_o[l] && tx_data_o[l*8 +: 8] == 8'hA0)); // R2
    AST_WR_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_done_o[l] |=> !busy_o[l]); // R6
    AST_RD_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_done_o[l] |=> !busy_o[l]); // R7
    AST_TIMEOUT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o[l] |-> !busy_o[l]); // R8
  end
endmodule

bind uart_reg_master uart_reg_master_chk #(
  .N_LINES(N_LINES), .SLAVES_PER_LINE(SLAVES_PER_LINE),
  .ADDR_W(ADDR_W), .N_DEV(N_DEV), .DEV_W(DEV_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_dev_i(req_dev_i), .req_reg_i(req_reg_i), .req_ack_o(req_ack_o),
  .req_nak_o(req_nak_o), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
  .busy_o(busy_o), .wr_done_o(wr_done_o), .rd_done_o(rd_done_o),
  .timeout_o(timeout_o), .clear_nf_i(clear_nf_i), .notfound_o(notfound_o)
);

// File: tb/tb_uart_reg_master.sv
module tb_uart_reg_master;
  localparam int TICK_PER = 100;
  localparam int TMO      = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         req_valid = 1'b0;
  logic [3:0]   req_dev = '0;
  logic [7:0]   req_reg = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_write = 1'b0;
  logic         req_ack, req_nak;
  logic [1:0]   tx_valid;
  logic [15:0]  tx_data;
  logic [1:0]   tx_ready;
  logic         rdy0 = 1'b1, rdy1 = 1'b1;
  int           rdy1_mode = 1;
  logic [1:0]   rx_valid = '0;
  logic [15:0]  rx_data = '0;
  logic [1:0]   busy, wr_done, rd_done, timeout;
  logic [127:0] reply;
  logic         clear_nf = 1'b0;
  logic [7:0]   notfound;

  assign tx_ready = {rdy1, rdy0};

  uart_reg_master dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick),
    .req_valid_i(req_valid), .req_dev_i(req_dev), .req_reg_i(req_reg),
    .req_wdata_i(req_wdata), .req_write_i(req_write),
    .req_ack_o(req_ack), .req_nak_o(req_nak),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .busy_o(busy), .wr_done_o(wr_done), .rd_done_o(rd_done),
    .timeout_o(timeout), .reply_o(reply),
    .clear_nf_i(clear_nf), .notfound_o(notfound)
  );

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // millisecond tick model
  initial forever begin
    repeat (TICK_PER - 1) @(posedge clk);
    #1 tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
  end

  // line 1 transmitter readiness: 0 never, 1 always, 2 alternating
  always @(posedge clk) begin
    #1;
    case (rdy1_mode)
      0:       rdy1 = 1'b0;
      1:       rdy1 = 1'b1;
      default: rdy1 = ~rdy1;
    endcase
  end

  // behavioural reference: captured frames, phase tick counts, not-found mask
  logic [7:0] cap [2][8];
  int   cap_n [2];
  bit   rd_armed [2], in_rx [2], counting [2], to_seen [2];
  int   tcnt [2], to_ticks [2], last_dev [2];
  logic [7:0] nf_model = '0;

  always @(negedge clk) if (rst_n) begin
    chk(notfound === nf_model, "R9/R10", "notfound per clock", 64'(notfound), 64'(nf_model));
    if (clear_nf) nf_model = '0;
    for (int l = 0; l < 2; l++) begin
      if (tx_valid[l] && tx_ready[l] && cap_n[l] < 8) begin
        cap[l][cap_n[l]] = tx_data[l*8 +: 8];
        cap_n[l]++;
        if (rd_armed[l] && cap_n[l] == 4) begin
          in_rx[l] = 1; tcnt[l] = 0; counting[l] = 1;
        end
      end
      if (timeout[l]) begin
        to_seen[l] = 1; to_ticks[l] = tcnt[l];
        if (in_rx[l]) nf_model[last_dev[l]] = 1'b1;
        in_rx[l] = 0; counting[l] = 0;
      end else if (wr_done[l] || rd_done[l]) begin
        in_rx[l] = 0; counting[l] = 0;
      end else if (counting[l] && tick) tcnt[l]++;
    end
  end

  function automatic logic [7:0] crc_upd(logic [7:0] c, logic [7:0] b);
    for (int j = 0; j < 8; j++) begin
      if (c[7] ^ b[0]) c = (c << 1) ^ 8'h07;
      else             c = c << 1;
      b = b >> 1;
    end
    return c;
  endfunction

  function automatic logic [7:0] raw_byte(int dev, logic [7:0] rg, logic [31:0] wd, bit wr, int i);
    case (i)
      0: return 8'hA0;
      1: return 8'(dev % 4);
      2: return {rg[6:0], wr};
      3: return wd[31:24];
      4: return wd[23:16];
      5: return wd[15:8];
      default: return wd[7:0];
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(int dev, logic [7:0] rg, logic [31:0] wd, bit wr, int i);
    int last = wr ? 7 : 3;
    logic [7:0] c = 8'h00;
    if (i != last) return raw_byte(dev, rg, wd, wr, i);
    for (int k = 0; k < last; k++) c = crc_upd(c, raw_byte(dev, rg, wd, wr, k));
    return c;
  endfunction

  task automatic request(int dev, logic [7:0] rg, logic [31:0] wd, bit wr, bit exp_ack, string req);
    @(posedge clk); #1;
    req_valid = 1; req_dev = 4'(dev); req_reg = rg; req_wdata = wd; req_write = wr;
    @(negedge clk); #1;
    chk(req_ack == exp_ack && req_nak == !exp_ack, req, "ack/nak",
        64'({req_ack, req_nak}), 64'({exp_ack, !exp_ack}));
    if (exp_ack) begin
      int l = dev / 4;
      cap_n[l] = 0; rd_armed[l] = !wr; in_rx[l] = 0;
      tcnt[l] = 0; counting[l] = 1; to_seen[l] = 0; last_dev[l] = dev;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic check_frame(int l, int dev, logic [7:0] rg, logic [31:0] wd, bit wr, string req);
    int n = wr ? 8 : 4;
    for (int g = 0; g < 2000 && cap_n[l] < n; g++) begin
      @(negedge clk); #1;
    end
    chk(cap_n[l] == n, req, "frame length", 64'(cap_n[l]), 64'(n));
    for (int i = 0; i < n; i++)
      chk(cap[l][i] == exp_byte(dev, rg, wd, wr, i), req, $sformatf("frame byte %0d", i),
          64'(cap[l][i]), 64'(exp_byte(dev, rg, wd, wr, i)));
  endtask

  task automatic drive_rx(int l, logic [63:0] bytes, int n, int delay);
    repeat (delay) @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      rx_valid[l] = 1'b1;
      rx_data[l*8 +: 8] = bytes[k*8 +: 8];
    end
    @(posedge clk); #1;
    rx_valid[l] = 1'b0;
  endtask

  task automatic wait_rd(int l, logic [63:0] exp, string req);
    bit seen = 0;
    for (int g = 0; g < 100 && !seen; g++) begin
      @(negedge clk); #1;
      seen = rd_done[l];
    end
    chk(seen, req, "rd_done pulse", 64'(seen), 64'd1);
    chk(reply[l*64 +: 64] == exp, req, "reply word", reply[l*64 +: 64], exp);
    @(negedge clk); #1;
    chk(busy[l] == 1'b0, req, "idle after reply", 64'(busy[l]), 64'd0);
  endtask

  task automatic wait_wr(int l, string req);
    bit seen = 0;
    for (int g = 0; g < 100 && !seen; g++) begin
      @(negedge clk); #1;
      seen = wr_done[l];
    end
    chk(seen, req, "wr_done pulse", 64'(seen), 64'd1);
    @(negedge clk); #1;
    chk(busy[l] == 1'b0, req, "idle after write", 64'(busy[l]), 64'd0);
  endtask

  task automatic wait_to(int l, string req);
    for (int g = 0; g < 5000 && !to_seen[l]; g++) begin
      @(negedge clk); #1;
    end
    chk(to_seen[l], req, "timeout pulse", 64'(to_seen[l]), 64'd1);
    chk(to_ticks[l] == TMO + 1, req, "ticks to timeout", 64'(to_ticks[l]), 64'(TMO + 1));
    chk(busy[l] == 1'b0, req, "idle after timeout", 64'(busy[l]), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    for (int l = 0; l < 2; l++) begin
      cap_n[l] = 0; rd_armed[l] = 0; in_rx[l] = 0; counting[l] = 0;
      to_seen[l] = 0; tcnt[l] = 0; to_ticks[l] = 0; last_dev[l] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(busy == 2'b00 && tx_valid == 2'b00, "R6", "reset idle", 64'({busy, tx_valid}), 64'd0);
    chk(notfound == 8'h00, "R10", "reset mask", 64'(notfound), 64'd0);

    // R1 R2 R3 R6: write on line 0, always-ready transmitter
    request(1, 8'h22, 32'hDEADBEEF, 1, 1, "R12");
    check_frame(0, 1, 8'h22, 32'hDEADBEEF, 1, "R1 R2 R3");
    wait_wr(0, "R6");

    // R4: malformed requests refused, nothing sent
    request(9, 8'h01, 32'h0, 0, 0, "R4 dev>=8");
    request(2, 8'h80, 32'h0, 1, 0, "R4 reg bit7");
    @(negedge clk); #1;
    chk(tx_valid == 2'b00 && busy == 2'b00, "R4", "no activity after refusal",
        64'({tx_valid, busy}), 64'd0);

    // R5 R7 R11: parallel reads, line 1 under backpressure
    rdy1_mode = 2;
    request(6, 8'h05, 32'h0, 0, 1, "R1 R5");
    request(5, 8'h11, 32'h1, 1, 0, "R4 busy line");
    drive_rx(0, 64'h0000_0000_0055_5555, 3, 0);
    request(0, 8'h3C, 32'h0, 0, 1, "R5 other line");
    check_frame(1, 6, 8'h05, 32'h0, 0, "R1 R3 read line1");
    check_frame(0, 0, 8'h3C, 32'h0, 0, "R3 read line0");
    drive_rx(1, 64'h8877_6655_4433_2211, 8, 5);
    wait_rd(1, 64'h8877_6655_4433_2211, "R7");
    drive_rx(0, 64'h0F1E_2D3C_4B5A_6978, 8, 0);
    wait_rd(0, 64'h0F1E_2D3C_4B5A_6978, "R7 R11");

    // R8 R9: silent slave on line 0
    request(2, 8'h07, 32'h0, 0, 1, "R12");
    check_frame(0, 2, 8'h07, 32'h0, 0, "R3");
    wait_to(0, "R8 rx");
    @(negedge clk); #1;
    chk(notfound == 8'h04, "R9", "mask after reply timeout", 64'(notfound), 64'h04);

    // R8 R9: transmitter stuck on line 1
    rdy1_mode = 0;
    repeat (3) @(posedge clk);
    request(7, 8'h01, 32'h1234_5678, 1, 1, "R12");
    wait_to(1, "R8 tx");
    @(negedge clk); #1;
    chk(notfound == 8'h04, "R9", "mask unchanged by send timeout", 64'(notfound), 64'h04);

    // R10: clear
    @(posedge clk); #1 clear_nf = 1'b1;
    @(posedge clk); #1 clear_nf = 1'b0;
    @(negedge clk); #1;
    chk(notfound == 8'h00, "R10", "mask cleared", 64'(notfound), 64'h00);

    repeat (5) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule